// File: doc/BRIEF.md
# Movable Sprite Object Generator

This block turns CPU register writes into per-pixel enable bits for five raster sprite objects: two players, two missiles and a ball. It has no sprite memory. Each player draws an 8-bit pattern register straight onto the line, and the missiles and the ball are solid strips whose width comes from a size field. The CPU can rewrite any register while a line is being drawn, and the change shows on the pixels that follow the write.

The pixel clock runs at three times the CPU clock, so one 76-CPU-cycle scanline lasts 228 pixel clocks. The first 68 clocks are horizontal blanking and the remaining 160 clocks are visible pixels. Each object has a position counter that advances only on visible clocks, so an object that is left alone stays where it is from line to line. Objects move only through a signed motion value per object. These values are applied to all five objects together when the CPU writes the motion strobe address: the counter is then stepped one pixel per blanking clock until the requested offset is reached.

A raster timing source drives `line_start_i` at the last clock of every line. The enable outputs go to a colour and priority stage outside this block.

Top module: `sprite_objgen`

## Requirements
- R1: A line is 228 clocks, counted from reset and restarted by `line_start_i`. Line clocks 0–67 are blanking and clocks 68–227 show pixels 0–159. The enables for line clock h appear on `obj_en_o` just after the edge at which the line counter holds h. Every enable bit is low for blanking clocks.
- R2: Players use the pattern registers at address 0 (player 0, `obj_en_o[0]`) and address 1 (player 1, `obj_en_o[1]`). A player draws 8 consecutive pixels starting at its position, bit 7 first and bit 0 last, and a pixel is enabled where the pattern bit is 1.
- R3: Missile size is taken from data bits [1:0] at address 2 (missile 0, `obj_en_o[2]`) and address 3 (missile 1, `obj_en_o[3]`). Code 0 gives 1 pixel, code 1 gives 2 pixels, and codes 2 and 3 give 4 pixels, all enabled from the object's position.
- R4: Ball size is taken from data bits [1:0] at address 4 (`obj_en_o[4]`). Codes 0, 1, 2 and 3 give 1, 2, 4 and 8 enabled pixels.
- R5: Addresses 5 to 9 hold the motion values of objects 0 to 4, taken from data bits [3:0] as two's complement (−8..+7). Writing a motion register by itself does not move any object.
- R6: A write to address 10 (data ignored) moves every object right by its motion value, or left when the value is negative. When the write falls on a blanking clock no later than clock 59, the move is complete before that line's first visible pixel. Motion values are retained, so a second strobe repeats the move.
- R7: A strobe written during the visible part of a line leaves that line unchanged and takes effect from the next line.
- R8: A pattern write on line clock h affects enables from line clock h+1 onward. The pixel at clock h still uses the old pattern.
- R9: Positions wrap modulo 160. The part of an object that runs past pixel 159 continues at pixel 0.
- R10: After reset all registers are zero, all objects sit at pixel 0 and `obj_en_o` is low.
- R11: If `line_start_i` cuts a line short after k visible clocks, every object shifts left by k pixels modulo 160, because position counters advance only on visible clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | Next clock is line clock 0 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 8 | Register write data |
| obj_en_o | output | 5 | Per-object pixel enables: P0, P1, M0, M1, ball |

## Verification
The bench places objects so they straddle the right edge. A design that drops the modulo-160 wrap would lose the tail of the object or draw garbage past pixel 159. It rewrites a player pattern in the middle of the object. An off-by-one in write timing would move the cut by a pixel, and a design that caches the pattern for the whole line would show no cut at all. It strobes motion during the visible region, and a design that steps at once would shift the current line. It writes motion registers without a strobe, repeats strobes, and cuts a line short with `line_start_i`. A design that advanced the counters during blanking, or ignored the restart, would then draw every object at the wrong place.

// File: rtl/sprite_objgen_pkg.sv
`timescale 1ns/1ps
package sprite_objgen_pkg;
  localparam int NUM_OBJ = 5;

  typedef enum logic [1:0] {
    KIND_PLAYER,
    KIND_MISSILE,
    KIND_BALL
  } obj_kind_e;

  // object order: player0, player1, missile0, missile1, ball
  function automatic obj_kind_e kind_of(int idx);
    if (idx < 2) return KIND_PLAYER;
    if (idx < 4) return KIND_MISSILE;
    return KIND_BALL;
  endfunction
endpackage

// File: rtl/sprite_hcount.sv
`timescale 1ns/1ps
module sprite_hcount #(
  parameter int LINE_CLKS  = 228,
  parameter int BLANK_CLKS = 68,
  parameter int HCNT_W     = $clog2(LINE_CLKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  output logic [HCNT_W-1:0] hcnt_o,
  output logic              blank_o
);
  localparam logic [HCNT_W-1:0] LAST_CLK = HCNT_W'(LINE_CLKS - 1);

  logic [HCNT_W-1:0] hcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hcnt_q <= '0;
    else if (line_start_i)      hcnt_q <= '0;
    else if (hcnt_q == LAST_CLK) hcnt_q <= '0;
    else                        hcnt_q <= hcnt_q + 1'b1;
  end

  assign hcnt_o  = hcnt_q;
  assign blank_o = hcnt_q < HCNT_W'(BLANK_CLKS);
endmodule

// File: rtl/sprite_regs.sv
`timescale 1ns/1ps
module sprite_regs #(
  parameter int NUM_OBJ = 5,
  parameter int PAT_W   = 8,
  parameter int MOT_W   = 4,
  parameter int ADDR_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [PAT_W-1:0]  wr_data_i,
  output logic [PAT_W-1:0]  cfg_o [NUM_OBJ],
  output logic [MOT_W-1:0]  mot_o [NUM_OBJ],
  output logic              strobe_o
);
  localparam logic [ADDR_W-1:0] STROBE_ADDR = ADDR_W'(2 * NUM_OBJ);

  for (genvar i = 0; i < NUM_OBJ; i++) begin : g_obj
    localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(i);
    localparam logic [ADDR_W-1:0] MOT_ADDR = ADDR_W'(NUM_OBJ + i);
    logic [PAT_W-1:0] cfg_q;
    logic [MOT_W-1:0] mot_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q <= '0;
        mot_q <= '0;
      end else if (wr_en_i) begin
        if (wr_addr_i == CFG_ADDR) cfg_q <= wr_data_i;
        if (wr_addr_i == MOT_ADDR) mot_q <= wr_data_i[MOT_W-1:0];
      end
    end

    assign cfg_o[i] = cfg_q;
    assign mot_o[i] = mot_q;
  end

  assign strobe_o = wr_en_i && (wr_addr_i == STROBE_ADDR);
endmodule

// File: rtl/sprite_pos_ctr.sv
`timescale 1ns/1ps
module sprite_pos_ctr #(
  parameter int VIS_PIX = 160,
  parameter int POS_W   = $clog2(VIS_PIX),
  parameter int MOT_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             blank_i,
  input  logic             strobe_i,
  input  logic [MOT_W-1:0] motion_i,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(VIS_PIX - 1);

  logic [POS_W-1:0] pos_q, pos_inc, pos_dec;
  logic [MOT_W:0]   mag_q, mot_ext, mot_abs;
  logic             back_q;

  assign pos_inc = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
  assign pos_dec = (pos_q == '0) ? LAST_POS : pos_q - 1'b1;
  assign mot_ext = {motion_i[MOT_W-1], motion_i};
  assign mot_abs = motion_i[MOT_W-1] ? (~mot_ext + 1'b1) : mot_ext;

  // moving right = counter held back one step per blanking clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      mag_q  <= '0;
      back_q <= 1'b0;
    end else begin
      if (strobe_i) begin
        mag_q  <= mot_abs;
        back_q <= !motion_i[MOT_W-1];
      end else if (blank_i && (mag_q != '0)) begin
        mag_q <= mag_q - 1'b1;
        pos_q <= back_q ? pos_dec : pos_inc;
      end
      if (!blank_i) pos_q <= pos_inc;
    end
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/sprite_shape.sv
`timescale 1ns/1ps
module sprite_shape import sprite_objgen_pkg::*; #(
  parameter obj_kind_e KIND  = KIND_BALL,
  parameter int        PAT_W = 8,
  parameter int        POS_W = 8
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic [PAT_W-1:0] cfg_i,
  output logic             pix_o
);
  if (KIND == KIND_PLAYER) begin : g_player
    localparam int IDX_W = $clog2(PAT_W);
    logic [IDX_W-1:0] bit_idx;
    assign bit_idx = IDX_W'(PAT_W - 1) - pos_i[IDX_W-1:0];
    assign pix_o   = (pos_i < POS_W'(PAT_W)) && cfg_i[bit_idx];
  end else if (KIND == KIND_MISSILE) begin : g_missile
    logic [POS_W-1:0] width;
    logic             unused_hi;
    always_comb begin
      case (cfg_i[1:0])
        2'd0:    width = POS_W'(1);
        2'd1:    width = POS_W'(2);
        default: width = POS_W'(4);
      endcase
    end
    assign unused_hi = ^cfg_i[PAT_W-1:2];
    assign pix_o     = pos_i < width;
  end else begin : g_ball
    logic [POS_W-1:0] width;
    logic             unused_hi;
    assign width     = POS_W'(1) << cfg_i[1:0];
    assign unused_hi = ^cfg_i[PAT_W-1:2];
    assign pix_o     = pos_i < width;
  end
endmodule

// File: rtl/sprite_objgen.sv
`timescale 1ns/1ps
module sprite_objgen import sprite_objgen_pkg::*; #(
  parameter int LINE_CLKS  = 228,
  parameter int BLANK_CLKS = 68,
  parameter int PAT_W      = 8,
  parameter int MOT_W      = 4,
  parameter int ADDR_W     = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_start_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [PAT_W-1:0]   wr_data_i,
  output logic [NUM_OBJ-1:0] obj_en_o
);
  localparam int VIS_PIX = LINE_CLKS - BLANK_CLKS;
  localparam int POS_W   = $clog2(VIS_PIX);
  localparam int HCNT_W  = $clog2(LINE_CLKS);

  logic [HCNT_W-1:0]        hcnt;
  logic                     blank;
  logic [PAT_W-1:0]         cfg [NUM_OBJ];
  logic [MOT_W-1:0]         mot [NUM_OBJ];
  logic                     strobe;
  logic [NUM_OBJ*POS_W-1:0] pos_flat;
  logic [NUM_OBJ-1:0]       pix, obj_en_q;

  sprite_hcount #(
    .LINE_CLKS (LINE_CLKS),
    .BLANK_CLKS(BLANK_CLKS),
    .HCNT_W    (HCNT_W)
  ) u_hcount (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_start_i(line_start_i),
    .hcnt_o      (hcnt),
    .blank_o     (blank)
  );

  sprite_regs #(
    .NUM_OBJ(NUM_OBJ),
    .PAT_W  (PAT_W),
    .MOT_W  (MOT_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .cfg_o    (cfg),
    .mot_o    (mot),
    .strobe_o (strobe)
  );

  for (genvar i = 0; i < NUM_OBJ; i++) begin : g_obj
    sprite_pos_ctr #(
      .VIS_PIX(VIS_PIX),
      .POS_W  (POS_W),
      .MOT_W  (MOT_W)
    ) u_pos (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .blank_i (blank),
      .strobe_i(strobe),
      .motion_i(mot[i]),
      .pos_o   (pos_flat[i*POS_W +: POS_W])
    );

    sprite_shape #(
      .KIND (kind_of(i)),
      .PAT_W(PAT_W),
      .POS_W(POS_W)
    ) u_shape (
      .pos_i(pos_flat[i*POS_W +: POS_W]),
      .cfg_i(cfg[i]),
      .pix_o(pix[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    obj_en_q <= '0;
    else if (blank) obj_en_q <= '0;
    else            obj_en_q <= pix;
  end

  assign obj_en_o = obj_en_q;
endmodule

// File: rtl/sprite_objgen_chk.sv
`timescale 1ns/1ps
module sprite_objgen_chk #(
  parameter int NUM_OBJ   = 5,
  parameter int POS_W     = 8,
  parameter int HCNT_W    = 8,
  parameter int VIS_PIX   = 160,
  parameter int LINE_CLKS = 228,
  parameter int PAT_W     = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     blank_i,
  input logic [HCNT_W-1:0]        hcnt_i,
  input logic [NUM_OBJ*POS_W-1:0] pos_i,
  input logic [NUM_OBJ-1:0]       obj_en_i
);
  function automatic logic [POS_W-1:0] nxt(logic [POS_W-1:0] p);
    return (p == POS_W'(VIS_PIX - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [POS_W-1:0] pos_w [NUM_OBJ];

  AST_BLANK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |=> obj_en_i == '0); // R1
  AST_LINE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt_i < HCNT_W'(LINE_CLKS)); // R1

  for (genvar i = 0; i < NUM_OBJ; i++) begin : g_obj
    assign pos_w[i] = pos_i[i*POS_W +: POS_W];
    AST_POS_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pos_w[i] < POS_W'(VIS_PIX)); // R9
    AST_POS_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !blank_i |=> pos_w[i] == nxt($past(pos_w[i]))); // R11
  end

  AST_P0_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    obj_en_i[0] |-> $past(pos_w[0]) < POS_W'(PAT_W)); // R2
  AST_P1_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    obj_en_i[1] |-> $past(pos_w[1]) < POS_W'(PAT_W)); // R2
  AST_M0_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    obj_en_i[2] |-> $past(pos_w[2]) < POS_W'(4)); // R3
  AST_M1_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    obj_en_i[3] |-> $past(pos_w[3]) < POS_W'(4)); // R3
  AST_BALL_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    obj_en_i[4] |-> $past(pos_w[4]) < POS_W'(8)); // R4
endmodule

bind sprite_objgen sprite_objgen_chk #(
  .NUM_OBJ  (NUM_OBJ),
  .POS_W    (POS_W),
  .HCNT_W   (HCNT_W),
  .VIS_PIX  (VIS_PIX),
  .LINE_CLKS(LINE_CLKS),
  .PAT_W    (PAT_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .blank_i (blank),
  .hcnt_i  (hcnt),
  .pos_i   (pos_flat),
  .obj_en_i(obj_en_o)
);

// File: tb/tb_sprite_objgen.sv
`timescale 1ns/1ps
module tb_sprite_objgen;
  localparam int LINE = 228;
  localparam int BLNK = 68;
  localparam int VIS  = 160;

  typedef struct packed {
    logic [7:0] p0, p1;
    logic [1:0] m0, m1, bl;
    logic [3:0] v0, v1, v2, v3, v4;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{8'hA5, 8'h3C, 2'd0, 2'd1, 2'd2, 4'd3, 4'd0, 4'hE, 4'd5, 4'h8},
    '{8'hFF, 8'h81, 2'd2, 2'd3, 2'd3, 4'd7, 4'd7, 4'd1, 4'hF, 4'd2},
    '{8'h01, 8'h80, 2'd1, 2'd0, 2'd1, 4'h9, 4'd4, 4'd6, 4'd0, 4'd7},
    '{8'h5A, 8'h00, 2'd3, 2'd2, 2'd0, 4'hC, 4'hD, 4'h8, 4'd2, 4'hF},
    '{8'hC3, 8'h7E, 2'd0, 2'd0, 2'd3, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0},
    '{8'h18, 8'hE7, 2'd1, 2'd2, 2'd2, 4'd6, 4'h9, 4'd3, 4'hA, 4'd1}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       line_start_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [4:0] obj_en_o;

  int n_chk = 0;
  int n_fail = 0;

  // model state
  int          x0 [5];
  logic [7:0]  m_cfg [5];
  logic [3:0]  m_mot [5];
  bit          defer;
  logic [3:0]  d_mot [5];

  // per-line write queue
  bit          wq_v [LINE];
  logic [3:0]  wq_a [LINE];
  logic [7:0]  wq_d [LINE];

  always #10 clk_i = ~clk_i;

  sprite_objgen dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_start_i(line_start_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .obj_en_o    (obj_en_o)
  );

  task automatic check(input logic [4:0] act, input logic [4:0] exp, input string tag, input int h);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s clk=%0d actual=%05b expected=%05b", tag, h, act, exp);
    end
  endtask

  function automatic logic [4:0] model_pix(int h);
    logic [4:0] r;
    int x, d, w;
    r = '0;
    if (h < BLNK) return r;
    x = h - BLNK;
    for (int i = 0; i < 5; i++) begin
      d = (x - x0[i] + VIS) % VIS;
      if (i < 2) begin
        if (d < 8) r[i] = m_cfg[i][7-d];
      end else if (i < 4) begin
        w = (m_cfg[i][1:0] == 2'd0) ? 1 : (m_cfg[i][1:0] == 2'd1) ? 2 : 4;
        r[i] = (d < w);
      end else begin
        w = 1 << m_cfg[i][1:0];
        r[i] = (d < w);
      end
    end
    return r;
  endfunction

  task automatic shift_all(input int amount [5]);
    for (int i = 0; i < 5; i++) x0[i] = ((x0[i] + amount[i]) % VIS + VIS) % VIS;
  endtask

  task automatic apply_write(input logic [3:0] a, input logic [7:0] d, input int h);
    int amt [5];
    if (a < 4'd5) m_cfg[a] = d;
    else if (a < 4'd10) m_mot[a-4'd5] = d[3:0];
    else if (a == 4'd10) begin
      if (h < BLNK) begin
        for (int i = 0; i < 5; i++) amt[i] = $signed(m_mot[i]);
        shift_all(amt);
      end else begin
        defer = 1'b1;
        for (int i = 0; i < 5; i++) d_mot[i] = m_mot[i];
      end
    end
  endtask

  task automatic sched(input int h, input logic [3:0] a, input logic [7:0] d);
    wq_v[h] = 1'b1;
    wq_a[h] = a;
    wq_d[h] = d;
  endtask

  task automatic run_line(input string tag, input int last_h);
    logic [4:0] exp;
    int amt [5];
    for (int h = 0; h <= last_h; h++) begin
      wr_en_i      = wq_v[h];
      wr_addr_i    = wq_a[h];
      wr_data_i    = wq_d[h];
      line_start_i = (h == last_h);
      exp = model_pix(h);
      @(posedge clk_i);
      #1;
      check(obj_en_o, exp, (h < BLNK) ? "R1" : tag, h);
      if (wq_v[h]) apply_write(wq_a[h], wq_d[h], h);
    end
    wr_en_i      = 1'b0;
    line_start_i = 1'b0;
    if (last_h < LINE - 1 && last_h >= BLNK) begin
      for (int i = 0; i < 5; i++) amt[i] = -(last_h - (BLNK - 1));
      shift_all(amt); // R11
    end
    if (defer) begin
      for (int i = 0; i < 5; i++) amt[i] = $signed(d_mot[i]);
      shift_all(amt); // R7
      defer = 1'b0;
    end
    for (int h = 0; h < LINE; h++) begin
      wq_v[h] = 1'b0;
      wq_a[h] = '0;
      wq_d[h] = '0;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    vec_t v;
    for (int i = 0; i < 5; i++) begin
      x0[i] = 0; m_cfg[i] = '0; m_mot[i] = '0; d_mot[i] = '0;
    end
    defer = 1'b0;
    for (int h = 0; h < LINE; h++) begin
      wq_v[h] = 1'b0; wq_a[h] = '0; wq_d[h] = '0;
    end

    repeat (3) @(posedge clk_i);
    #1;
    check(obj_en_o, 5'b0, "R10", -1);
    rst_ni = 1'b1;

    // R10: idle line after reset, objects at pixel 0
    run_line("R10", LINE - 1);

    // R9: move everything left by 3 so objects straddle the right edge
    sched(1, 4'd0, 8'hFF);
    sched(2, 4'd1, 8'hF1);
    sched(3, 4'd2, 8'h02);
    sched(4, 4'd3, 8'h01);
    sched(5, 4'd4, 8'h03);
    for (int i = 0; i < 5; i++) sched(6 + i, 4'(5 + i), 8'h0D);
    sched(11, 4'd10, 8'h00);
    run_line("R9", LINE - 1);

    // table: R2 R3 R4 R6
    for (int k = 0; k < 6; k++) begin
      v = VEC[k];
      sched(1, 4'd0, v.p0);
      sched(2, 4'd1, v.p1);
      sched(3, 4'd2, {6'd0, v.m0});
      sched(4, 4'd3, {6'd0, v.m1});
      sched(5, 4'd4, {6'd0, v.bl});
      sched(6, 4'd5, {4'd0, v.v0});
      sched(7, 4'd6, {4'd0, v.v1});
      sched(8, 4'd7, {4'd0, v.v2});
      sched(9, 4'd8, {4'd0, v.v3});
      sched(10, 4'd9, {4'd0, v.v4});
      sched(11, 4'd10, 8'h5A);
      run_line("R2 R3 R4 R6", LINE - 1);
    end

    // R5: motion writes alone leave positions untouched
    sched(6, 4'd5, 8'hF5);
    sched(7, 4'd6, 8'h04);
    sched(8, 4'd7, 8'h0A);
    sched(9, 4'd8, 8'h07);
    sched(10, 4'd9, 8'h08);
    run_line("R5", LINE - 1);

    // R6: two strobes in one blanking interval repeat the move
    sched(2, 4'd10, 8'h00);
    sched(30, 4'd10, 8'hFF);
    run_line("R6", LINE - 1);

    // R7: strobe in the visible region
    sched(150, 4'd10, 8'h00);
    run_line("R7", LINE - 1);
    run_line("R7", LINE - 1);

    // R8: rewrite player 0 in the middle of its drawing
    sched(1, 4'd0, 8'hFF);
    sched(BLNK + ((x0[0] + 3) % VIS), 4'd0, 8'h00);
    run_line("R8", LINE - 1);

    // R11: cut a line short, then a full line
    sched(1, 4'd0, 8'hB7);
    run_line("R11", 120);
    run_line("R11", LINE - 1);

    summary();
    $finish;
  end
endmodule